// File: doc/BRIEF.md
# Board-Level Scan Compare and Brake Unit

This unit sits on every board that hangs on a shared multi-drop test bus. While the bus runs in concurrent mode, each board checks its own local scan-path outputs against a reference stream that the bus master broadcasts to all boards at once. The bus line that normally returns scan data is turned around to carry the expected bit into the board. The asynchronous-reset line carries a per-bit mask that marks don't-care bits. Each selected local path is compared bit by bit in every shift cycle. A mismatch raises a sticky per-path fail flag. When auto-braking is enabled, the same mismatch also raises a per-path brake. The brake halts that path so its contents stay intact for diagnosis. The master can also force brakes on any path, for example after the last vector of a sequence.

The unit also accumulates two statistics: a saturating count of failing shift cycles, and the position of the first failing bit within its shift run. The flags and statistics are read back through an ordinary boundary-scan style data register with capture and shift controls. The TAP state machine and board address decoding lie outside the unit. They supply the shift-state, reset-state and clear strobes.

The compare input is a qualified stream: a bit is valid in any cycle where `in_shift` is high. There is no ready signal, because a test clock cannot be stalled. Every valid bit is consumed at the rising edge it is presented on, and no back-pressure exists.

Top module: `scan_cmp_brake`

## Requirements
- R1: While `rst_n` is low and after it is released, `fail`, `brake`, `fail_cnt` and `first_idx` are all zero.
- R2: A path is compared only at an edge where `conc_mode`, `in_shift` and that path's `path_sel` bit are all 1. Otherwise its fail flag and the count are unchanged.
- R3: A compared, unmasked path whose `scan_out` bit differs from `exp_bit` sets its `fail` bit at that edge. Fail bits stay set until cleared.
- R4: When `mask_bit` is 1 at an edge, no path records a mismatch at that edge.
- R5: When `auto_brake` is 1, a mismatch sets the path's `brake` bit at the same edge as its `fail` bit. Once a path is braked, it takes part in no further compares or counts.
- R6: A 1 in `brake_force[p]` sets `brake[p]` at that edge, in any mode.
- R7: `tlr` or `clr_fail` high at an edge clears `fail`, `brake`, `fail_cnt`, `first_idx` and the shift index. A clear wins over any set at the same edge.
- R8: `fail_cnt` rises by exactly one at each edge where at least one path records a mismatch. It holds at its all-ones maximum.
- R9: The shift index is 0 at the first shift edge of a run and rises by one per shift edge, saturating at all-ones. It returns to 0 at any edge where `in_shift` is low. `first_idx` takes the index of the first mismatching edge since the last clear and holds it.
- R10: `res_capture` (which wins over `res_shift`) loads the register with `{first_idx, fail_cnt, fail}`, with `fail[0]` at bit 0. `res_shift` moves the register one place toward bit 0 and enters `res_tdi` at the top. `res_tdo` is always bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; compares are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlr | input | 1 | TAP is in its reset state (clears results) |
| clr_fail | input | 1 | Clear-results instruction strobe |
| conc_mode | input | 1 | Concurrent compare mode enable |
| in_shift | input | 1 | TAP in a shift state (compare stream valid) |
| path_sel | input | NUM_PATHS | Local paths taking part in the compare |
| scan_out | input | NUM_PATHS | Current output bit of each local path |
| exp_bit | input | 1 | Broadcast expected bit |
| mask_bit | input | 1 | Broadcast don't-care bit |
| auto_brake | input | 1 | Brake a path on its first mismatch |
| brake_force | input | NUM_PATHS | Explicit per-path brake request |
| res_capture | input | 1 | Load the results register |
| res_shift | input | 1 | Shift the results register |
| res_tdi | input | 1 | Serial input of the results register |
| res_tdo | output | 1 | Serial output of the results register |
| fail | output | NUM_PATHS | Sticky per-path fail flags |
| brake | output | NUM_PATHS | Per-path brake (stop) outputs |
| fail_cnt | output | CNT_W | Saturating count of failing shift edges |
| first_idx | output | IDX_W | Shift index of the first mismatch |

## Verification
Every result is registered once at the edge that samples its cause. `fail`, `brake`, `fail_cnt` and `first_idx` therefore change at that same edge and are due one cycle after the stimulus is presented. The results register has the same latency: its bit 0 appears on `res_tdo` right after the capture edge, and each later shift edge brings the next bit. The bench drives inputs a short time after a rising edge. Its model is advanced at the next rising edge, and all outputs are compared two nanoseconds after that edge, so each expected value is compared exactly one edge after its stimulus.

// File: rtl/scb_pkg.sv
package scb_pkg;
  // Width of the readback register for a given configuration.
  function automatic int res_width(input int paths, input int cnt_w, input int idx_w);
    return paths + cnt_w + idx_w;
  endfunction

  // Why the results are being wiped.
  typedef enum logic [1:0] {
    CLR_NONE  = 2'b00,
    CLR_RESET = 2'b01,
    CLR_INSTR = 2'b10,
    CLR_BOTH  = 2'b11
  } clr_cause_e;
endpackage

// File: rtl/scb_lane.sv
module scb_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cmp_en,
  input  logic sel,
  input  logic scan_bit,
  input  logic exp_bit,
  input  logic mask_bit,
  input  logic auto_brake,
  input  logic force_brake,
  output logic miss,
  output logic fail,
  output logic brake
);
  logic fail_q, brake_q;

  // A braked path is frozen and no longer takes part.
  assign miss = cmp_en & sel & ~brake_q & ~mask_bit & (scan_bit ^ exp_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q  <= 1'b0;
      brake_q <= 1'b0;
    end else if (clr) begin
      fail_q  <= 1'b0;
      brake_q <= 1'b0;
    end else begin
      fail_q  <= fail_q | miss;
      brake_q <= brake_q | force_brake | (miss & auto_brake);
    end
  end

  assign fail  = fail_q;
  assign brake = brake_q;
endmodule

// File: rtl/scb_stats.sv
module scb_stats #(
  parameter int CNT_W = 8,
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_shift,
  input  logic             miss_any,
  output logic [CNT_W-1:0] fail_cnt,
  output logic [IDX_W-1:0] first_idx
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] first_q;
  logic             have_first;

  // Position within the current shift run.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              idx_q <= '0;
    else if (clr)            idx_q <= '0;
    else if (!in_shift)      idx_q <= '0;
    else if (idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
  end

  // Saturating count of failing edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clr)                        cnt_q <= '0;
    else if (miss_any && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // Index of the first failing edge since the last clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= '0;
      have_first <= 1'b0;
    end else if (clr) begin
      first_q    <= '0;
      have_first <= 1'b0;
    end else if (miss_any && !have_first) begin
      first_q    <= idx_q;
      have_first <= 1'b1;
    end
  end

  assign fail_cnt  = cnt_q;
  assign first_idx = first_q;
endmodule

// File: rtl/scb_result_dr.sv
module scb_result_dr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic         shift,
  input  logic         tdi,
  input  logic [W-1:0] snap,
  output logic         tdo
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sr_q <= '0;
    else if (capture) sr_q <= snap;
    else if (shift)   sr_q <= {tdi, sr_q[W-1:1]};
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/scan_cmp_brake.sv
module scan_cmp_brake #(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tlr,
  input  logic                 clr_fail,
  input  logic                 conc_mode,
  input  logic                 in_shift,
  input  logic [NUM_PATHS-1:0] path_sel,
  input  logic [NUM_PATHS-1:0] scan_out,
  input  logic                 exp_bit,
  input  logic                 mask_bit,
  input  logic                 auto_brake,
  input  logic [NUM_PATHS-1:0] brake_force,
  input  logic                 res_capture,
  input  logic                 res_shift,
  input  logic                 res_tdi,
  output logic                 res_tdo,
  output logic [NUM_PATHS-1:0] fail,
  output logic [NUM_PATHS-1:0] brake,
  output logic [CNT_W-1:0]     fail_cnt,
  output logic [IDX_W-1:0]     first_idx
);
  import scb_pkg::*;

  localparam int RES_W = res_width(NUM_PATHS, CNT_W, IDX_W);

  clr_cause_e           cause;
  logic                 clr;
  logic                 cmp_en;
  logic [NUM_PATHS-1:0] miss;

  assign cause  = clr_cause_e'({clr_fail, tlr});
  assign clr    = (cause != CLR_NONE);
  assign cmp_en = conc_mode & in_shift;

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_lane
    scb_lane u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr),
      .cmp_en      (cmp_en),
      .sel         (path_sel[p]),
      .scan_bit    (scan_out[p]),
      .exp_bit     (exp_bit),
      .mask_bit    (mask_bit),
      .auto_brake  (auto_brake),
      .force_brake (brake_force[p]),
      .miss        (miss[p]),
      .fail        (fail[p]),
      .brake       (brake[p])
    );
  end

  scb_stats #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_stats (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .in_shift  (in_shift),
    .miss_any  (|miss),
    .fail_cnt  (fail_cnt),
    .first_idx (first_idx)
  );

  scb_result_dr #(.W(RES_W)) u_dr (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (res_capture),
    .shift   (res_shift),
    .tdi     (res_tdi),
    .snap    ({first_idx, fail_cnt, fail}),
    .tdo     (res_tdo)
  );
endmodule

// File: rtl/scan_cmp_brake_chk.sv
module scan_cmp_brake_chk #(
  parameter int NUM_PATHS = 4,
  parameter int CNT_W     = 8,
  parameter int IDX_W     = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tlr,
  input logic                 clr_fail,
  input logic                 conc_mode,
  input logic                 in_shift,
  input logic                 mask_bit,
  input logic                 auto_brake,
  input logic [NUM_PATHS-1:0] brake_force,
  input logic [NUM_PATHS-1:0] fail,
  input logic [NUM_PATHS-1:0] brake,
  input logic [CNT_W-1:0]     fail_cnt,
  input logic [IDX_W-1:0]     first_idx
);
  logic clr_any;
  assign clr_any = tlr | clr_fail;

  assert_reset_zero_R1: assert property (@(posedge clk)
    !rst_n |=> (fail == '0 && brake == '0 && fail_cnt == '0 && first_idx == '0));

  assert_idle_no_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && (!in_shift || !conc_mode)) |=> (fail == $past(fail) && fail_cnt == $past(fail_cnt)));

  assert_fail_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> ((fail & $past(fail)) == $past(fail)));

  assert_mask_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && mask_bit) |=> (fail == $past(fail) && fail_cnt == $past(fail_cnt)));

  assert_auto_brake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_any && auto_brake) |=> ((fail & ~$past(fail) & ~brake) == '0));

  assert_force_brake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> ((brake & $past(brake_force)) == $past(brake_force)));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (fail == '0 && brake == '0 && fail_cnt == '0 && first_idx == '0));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> (fail_cnt == $past(fail_cnt) || fail_cnt == $past(fail_cnt) + 1'b1));

  assert_count_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_any |=> (fail_cnt >= $past(fail_cnt)));
endmodule

bind scan_cmp_brake scan_cmp_brake_chk #(
  .NUM_PATHS(NUM_PATHS), .CNT_W(CNT_W), .IDX_W(IDX_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tlr         (tlr),
  .clr_fail    (clr_fail),
  .conc_mode   (conc_mode),
  .in_shift    (in_shift),
  .mask_bit    (mask_bit),
  .auto_brake  (auto_brake),
  .brake_force (brake_force),
  .fail        (fail),
  .brake       (brake),
  .fail_cnt    (fail_cnt),
  .first_idx   (first_idx)
);

// File: tb/scan_cmp_brake_test.sv
module scan_cmp_brake_test;
  localparam int NP   = 2;
  localparam int CW   = 3;
  localparam int IW   = 4;
  localparam int RW   = NP + CW + IW;
  localparam int CMAX = (1 << CW) - 1;
  localparam int IMAX = (1 << IW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tlr = 0, clr_fail = 0, conc_mode = 0, in_shift = 0;
  logic [NP-1:0] path_sel = '0, scan_out = '0, brake_force = '0;
  logic exp_bit = 0, mask_bit = 0, auto_brake = 0;
  logic res_capture = 0, res_shift = 0, res_tdi = 0;
  logic res_tdo;
  logic [NP-1:0] fail, brake;
  logic [CW-1:0] fail_cnt;
  logic [IW-1:0] first_idx;

  always #4 clk = ~clk;

  scan_cmp_brake #(.NUM_PATHS(NP), .CNT_W(CW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .tlr(tlr), .clr_fail(clr_fail),
    .conc_mode(conc_mode), .in_shift(in_shift), .path_sel(path_sel),
    .scan_out(scan_out), .exp_bit(exp_bit), .mask_bit(mask_bit),
    .auto_brake(auto_brake), .brake_force(brake_force),
    .res_capture(res_capture), .res_shift(res_shift), .res_tdi(res_tdi),
    .res_tdo(res_tdo), .fail(fail), .brake(brake),
    .fail_cnt(fail_cnt), .first_idx(first_idx)
  );

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;

  // Expected state, built from the requirements.
  int m_fail[NP];
  int m_brake[NP];
  int m_cnt, m_first, m_idx, m_have;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int p = 0; p < NP; p++) begin m_fail[p] = 0; m_brake[p] = 0; end
    m_cnt = 0; m_first = 0; m_idx = 0; m_have = 0;
  endtask

  task automatic model_edge();
    int any;
    if (tlr || clr_fail) begin
      model_clear();   // R7
      return;
    end
    any = 0;
    for (int p = 0; p < NP; p++) begin
      int mis;
      mis = (conc_mode && in_shift && path_sel[p] && !m_brake[p] && !mask_bit
             && (scan_out[p] != exp_bit)) ? 1 : 0;
      if (mis) begin
        any = 1;
        m_fail[p] = 1;
        if (auto_brake) m_brake[p] = 1;
      end
      if (brake_force[p]) m_brake[p] = 1;
    end
    if (any && m_cnt < CMAX) m_cnt++;
    if (any && !m_have) begin m_first = m_idx; m_have = 1; end
    m_idx = in_shift ? ((m_idx < IMAX) ? m_idx + 1 : IMAX) : 0;
  endtask

  function automatic int pack_vec(input int v[NP]);
    int r = 0;
    for (int p = 0; p < NP; p++) r |= (v[p] << p);
    return r;
  endfunction

  task automatic tick(input string tag);
    @(posedge clk);
    model_edge();
    #2;
    chk({tag, " fail"},  fail,      pack_vec(m_fail));
    chk({tag, " brake"}, brake,     pack_vec(m_brake));
    chk({tag, " count"}, fail_cnt,  m_cnt);
    chk({tag, " first"}, first_idx, m_first);
  endtask

  task automatic idle_inputs();
    tlr = 0; clr_fail = 0; conc_mode = 0; in_shift = 0; path_sel = '0;
    scan_out = '0; exp_bit = 0; mask_bit = 0; auto_brake = 0; brake_force = '0;
    res_capture = 0; res_shift = 0; res_tdi = 0;
  endtask

  task automatic do_clear();
    idle_inputs(); clr_fail = 1;
    tick("R7 clear");
    clr_fail = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      vectors++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_clear();
    idle_inputs();
    repeat (3) @(posedge clk);
    #2;
    // R1: outputs held at zero during reset
    chk("R1 fail", fail, 0);
    chk("R1 brake", brake, 0);
    chk("R1 count", fail_cnt, 0);
    chk("R1 first", first_idx, 0);
    rst_n = 1'b1;
    tick("R1 after release");

    // R2 R3 R4 R5: exhaustive sweep of one compare edge from a cleared state
    for (int v = 0; v < 512; v++) begin
      do_clear();
      conc_mode  = v[0];
      in_shift   = v[1];
      path_sel   = v[3:2];
      mask_bit   = v[4];
      exp_bit    = v[5];
      scan_out   = v[7:6];
      auto_brake = v[8];
      tick("R2_R3_R4_R5 sweep");
    end

    // R8 R9: long shift run, path 0 mismatches from index 3 onward
    do_clear();
    conc_mode = 1; path_sel = 2'b01; exp_bit = 0; in_shift = 1;
    for (int i = 0; i < 20; i++) begin
      scan_out = (i >= 3) ? 2'b01 : 2'b00;
      tick("R8_R9 run");
    end
    chk("R9 first index", first_idx, 3);
    chk("R8 saturated", fail_cnt, CMAX);

    // R9: index returns to zero when shifting pauses; first_idx held
    in_shift = 0; tick("R9 pause");
    in_shift = 1; scan_out = 2'b00; tick("R9 restart");
    chk("R9 held", first_idx, 3);

    // R9: first mismatch in a second run after clear, at index 5
    do_clear();
    conc_mode = 1; path_sel = 2'b10; exp_bit = 1; in_shift = 1;
    for (int i = 0; i < 8; i++) begin
      scan_out = (i == 5 || i == 7) ? 2'b00 : 2'b10;
      tick("R9 second run");
    end
    chk("R9 index 5", first_idx, 5);
    chk("R8 two edges", fail_cnt, 2);

    // R5: auto brake freezes a path; later mismatches are not counted
    do_clear();
    conc_mode = 1; in_shift = 1; path_sel = 2'b11; auto_brake = 1; exp_bit = 0;
    scan_out = 2'b01; tick("R5 brake set");
    for (int i = 0; i < 4; i++) tick("R5 braked path ignored");
    chk("R5 count stays", fail_cnt, 1);
    scan_out = 2'b11; tick("R5 other path");
    chk("R5 both braked", brake, 3);

    // R6: forced brake in any mode
    do_clear();
    brake_force = 2'b10; tick("R6 force");
    brake_force = 2'b00; tick("R6 hold");
    chk("R6 brake1", brake, 2);

    // R7: clear wins over a simultaneous mismatch, by either source
    do_clear();
    conc_mode = 1; in_shift = 1; path_sel = 2'b11; scan_out = 2'b11; exp_bit = 0;
    tick("R7 setup");
    tlr = 1; tick("R7 tlr priority");
    tlr = 0; clr_fail = 1; brake_force = 2'b11; tick("R7 clr priority");
    clr_fail = 0; brake_force = 2'b00;

    // R10: capture and shift out the results
    do_clear();
    conc_mode = 1; in_shift = 1; path_sel = 2'b10; exp_bit = 0;
    scan_out = 2'b00; tick("R10 setup");
    tick("R10 setup");
    scan_out = 2'b10; tick("R10 setup");
    tick("R10 setup");
    idle_inputs();
    begin
      int snap;
      snap = (m_first << (NP + CW)) | (m_cnt << NP) | pack_vec(m_fail);
      res_capture = 1; tick("R10 capture");
      res_capture = 0; res_shift = 1; res_tdi = 1;
      for (int b = 0; b < RW; b++) begin
        chk("R10 tdo bit", res_tdo, (snap >> b) & 1);
        tick("R10 shift");
      end
      // Fill bits from res_tdi now emerge at bit 0
      chk("R10 tdi fill", res_tdo, 1);
      res_shift = 0;
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule